// File: doc/BRIEF.md
# Oscillator Control Word Loop Filter

This block keeps the control word for a digitally controlled oscillator and nudges it toward a target frequency. The word is 12 bits: a 4-bit coarse divider in the upper nibble and an 8-bit fine stage setting below it. Each time an external frequency comparator pulses its valid strobe with a band code, the filter adds a band-dependent step to the whole word or subtracts it. Steps are uneven: large when the error is large and small near lock. A carry or borrow out of the stage field moves the divider field.

The word is free to run past the normal range of 0x000 to 0x9FF, and it wraps modulo 4096. The divider value that goes to the oscillator is clamped, so raw divider codes 0xA to 0xF drive the oscillator as 0x9, its slowest setting. A stable flag reports whether the most recent band lay within five percent of nominal.

Top module: `dco_loop_filter`

## Requirements
- R1: On a synchronous reset, with `rstN` low at a clock edge, the word is loaded with parameter RESET_WORD (default 0x480) and `stableOut` is cleared.
- R2: The word changes only on a clock edge where `bandValid` is high. At every other edge the word and `stableOut` hold their values.
- R3: `bandCode` 0 (base clock below 0.85 of nominal) subtracts 32 from the word, code 1 (0.85 to 0.95) subtracts 8, and code 2 (0.95 to 1.0) subtracts 1.
- R4: `bandCode` 3 (1.0 to 1.05) adds 1, code 4 (1.05 to 1.15) adds 8, and code 5 (above 1.15) adds 32.
- R5: The word is a single 12-bit value: `divRaw` is bits 11:8 and `stageRaw` is bits 7:0. A carry or borrow out of the stage field changes the divider field.
- R6: Arithmetic is modulo 4096. For example, 0x000 minus 1 gives 0xFFF, and 0xFFF plus 32 gives 0x01F.
- R7: `divEff` equals `divRaw` when `divRaw` is 9 or less, and equals 9 when `divRaw` is 0xA to 0xF.
- R8: On a valid strobe, `stableOut` becomes 1 when the code is 2 or 3 and 0 when the code is 0, 1, 4 or 5.
- R9: A valid strobe carrying code 6 or 7 leaves the word unchanged and holds `stableOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| bandValid | input | 1 | Update strobe from the frequency comparator |
| bandCode | input | 3 | Error band, 0 = slowest through 5 = fastest |
| divRaw | output | 4 | Raw divider field (word bits 11:8) |
| stageRaw | output | 8 | Stage field (word bits 7:0) |
| divEff | output | 4 | Divider as presented to the oscillator, clamped to 9 |
| stableOut | output | 1 | Last reported error was within five percent |

## Verification
Every band code is applied from a mid-range word, which separates the six step sizes and their signs. Words near a stage boundary (for example 0x4FF plus 1, or 0x500 minus 1) show whether a carry or borrow reaches the divider field. Words at the ends of the range (0x000 minus 1, 0xFFF plus 32) separate wrapping from saturation. Walking the word through 0x9FF and 0xA00 checks the clamp on the effective divider. Idle cycles and the illegal codes 6 and 7 are sent between known updates to show that nothing moves, and the stable flag is compared after inner-band and outer-band updates.

// File: rtl/dco_lf_pkg.sv
package dco_lf_pkg;
  localparam int DIV_W   = 4;
  localparam int STAGE_W = 8;
  localparam int WORD_W  = DIV_W + STAGE_W;
  localparam int CODE_W  = 3;

  typedef enum logic [CODE_W-1:0] {
    BAND_VSLOW = 3'd0,
    BAND_SLOW  = 3'd1,
    BAND_LOW   = 3'd2,
    BAND_HIGH  = 3'd3,
    BAND_FAST  = 3'd4,
    BAND_VFAST = 3'd5
  } band_e;

  typedef struct packed {
    logic                load;
    logic                subtract;
    logic [WORD_W-1:0]   step;
    logic                stableNext;
  } ctrl_t;
endpackage

// File: rtl/dco_lf_ctrl.sv
module dco_lf_ctrl
  import dco_lf_pkg::*;
#(
  parameter int BIG_STEP = 32,
  parameter int MID_STEP = 8,
  parameter int SML_STEP = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bandValid,
  input  logic [CODE_W-1:0] bandCode,
  output ctrl_t             ctrl
);
  logic legal;

  always_comb begin
    ctrl = '0;
    legal = (bandCode <= CODE_W'(BAND_VFAST));
    ctrl.load = bandValid && legal;
    case (bandCode)
      BAND_VSLOW: begin ctrl.subtract = 1'b1; ctrl.step = WORD_W'(BIG_STEP); end
      BAND_SLOW:  begin ctrl.subtract = 1'b1; ctrl.step = WORD_W'(MID_STEP); end
      BAND_LOW:   begin ctrl.subtract = 1'b1; ctrl.step = WORD_W'(SML_STEP); ctrl.stableNext = 1'b1; end
      BAND_HIGH:  begin ctrl.step = WORD_W'(SML_STEP); ctrl.stableNext = 1'b1; end
      BAND_FAST:  ctrl.step = WORD_W'(MID_STEP);
      BAND_VFAST: ctrl.step = WORD_W'(BIG_STEP);
      default:    ctrl.step = '0;
    endcase
  end

  // R9
  illegal_noload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bandCode > 3'd5) |-> !ctrl.load);
  // R2
  idle_noload_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bandValid |-> !ctrl.load);
endmodule

// File: rtl/dco_lf_datapath.sv
module dco_lf_datapath
  import dco_lf_pkg::*;
#(
  parameter logic [WORD_W-1:0] RESET_WORD = 12'h480,
  parameter int                DIV_MAX    = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_t              ctrl,
  output logic [DIV_W-1:0]   divRaw,
  output logic [STAGE_W-1:0] stageRaw,
  output logic [DIV_W-1:0]   divEff,
  output logic               stableOut
);
  logic [WORD_W-1:0] wordQ, wordNext;
  logic              stableQ;

  always_comb begin
    if (ctrl.subtract) wordNext = wordQ - ctrl.step;
    else               wordNext = wordQ + ctrl.step;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordQ   <= RESET_WORD;
      stableQ <= 1'b0;
    end else if (ctrl.load) begin
      wordQ   <= wordNext;
      stableQ <= ctrl.stableNext;
    end
  end

  assign divRaw    = wordQ[WORD_W-1:STAGE_W];
  assign stageRaw  = wordQ[STAGE_W-1:0];
  assign divEff    = (divRaw > DIV_W'(DIV_MAX)) ? DIV_W'(DIV_MAX) : divRaw;
  assign stableOut = stableQ;

  // R7
  div_clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    divEff <= DIV_W'(DIV_MAX));
  // R2
  hold_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctrl.load) && $past(rstN) |-> $stable(wordQ) && $stable(stableQ));
  // R5
  div_moves_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctrl.load) && $past(rstN) && $past(ctrl.step) == 12'd1 && !$past(ctrl.subtract)
      && $past(wordQ[7:0]) == 8'hFF |-> divRaw == $past(divRaw) + 4'd1);
endmodule

// File: rtl/dco_loop_filter.sv
module dco_loop_filter
  import dco_lf_pkg::*;
#(
  parameter logic [11:0] RESET_WORD = 12'h480
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bandValid,
  input  logic [2:0] bandCode,
  output logic [3:0] divRaw,
  output logic [7:0] stageRaw,
  output logic [3:0] divEff,
  output logic       stableOut
);
  ctrl_t ctrl;

  dco_lf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .bandValid(bandValid), .bandCode(bandCode), .ctrl(ctrl));

  dco_lf_datapath #(.RESET_WORD(RESET_WORD)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .divRaw(divRaw), .stageRaw(stageRaw),
    .divEff(divEff), .stableOut(stableOut));

  // R8
  stable_inner_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(bandValid) && $past(rstN) && ($past(bandCode) == 3'd2 || $past(bandCode) == 3'd3)
      |-> stableOut);
endmodule

// File: tb/dco_loop_filter_bench.sv
module dco_loop_filter_bench;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rstN = 0, bandValid = 0;
  logic [2:0] bandCode = 0;
  logic [3:0] divRaw, divEff;
  logic [7:0] stageRaw;
  logic stableOut;
  int checks = 0, fails = 0;
  logic [11:0] model;
  logic modelStable;

  always #(CLK_PERIOD/2) clk = ~clk;

  dco_loop_filter u_dco_loop_filter (.clk, .rstN, .bandValid, .bandCode,
    .divRaw, .stageRaw, .divEff, .stableOut);

  task automatic check(string req, logic [11:0] expW, logic expS);
    logic [3:0] expE;
    expE = (expW[11:8] > 4'd9) ? 4'd9 : expW[11:8];
    checks++;
    if ({divRaw, stageRaw} !== expW || stableOut !== expS || divEff !== expE) begin
      fails++;
      $display("FAIL %s: word=%h eff=%h st=%b expected word=%h eff=%h st=%b",
               req, {divRaw, stageRaw}, divEff, stableOut, expW, expE, expS);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0; bandValid = 0;
    @(negedge clk); rstN = 1;
    model = 12'h480; modelStable = 0;
  endtask

  task automatic strobe(logic [2:0] code);
    @(negedge clk); bandValid = 1; bandCode = code;
    @(negedge clk); bandValid = 0;
    case (code)
      3'd0: model = model - 12'd32;
      3'd1: model = model - 12'd8;
      3'd2: model = model - 12'd1;
      3'd3: model = model + 12'd1;
      3'd4: model = model + 12'd8;
      3'd5: model = model + 12'd32;
      default: ;
    endcase
    if (code <= 3'd5) modelStable = (code == 3'd2 || code == 3'd3);
  endtask

  task automatic setWord(logic [11:0] target);
    while (model != target) begin
      if (model - target >= 12'd32 && model - target < 12'd2048) strobe(3'd0);
      else if (target - model >= 12'd32 && target - model < 12'd2048) strobe(3'd5);
      else if (model > target) strobe(3'd2);
      else strobe(3'd3);
    end
  endtask

  task automatic testReset();
    doReset();
    check("R1 reset", 12'h480, 0);
  endtask

  task automatic testSteps();
    for (int c = 0; c < 6; c++) begin
      strobe(3'(c));
      check(c < 3 ? "R3 subtract step" : "R4 add step", model, modelStable);
      check("R8 stable flag", model, (c == 2 || c == 3));
    end
  endtask

  task automatic testIdle();
    logic [11:0] w;
    strobe(3'd3);
    w = model;
    repeat (5) @(negedge clk);
    check("R2 idle hold", w, 1);
    bandCode = 3'd0; repeat (3) @(negedge clk);
    check("R2 code without strobe", w, 1);
    strobe(3'd6); check("R9 code 6 ignored", w, 1);
    strobe(3'd7); check("R9 code 7 ignored", w, 1);
  endtask

  task automatic testCarry();
    setWord(12'h4FF); strobe(3'd3); check("R5 carry into divider", 12'h500, 1);
    strobe(3'd2); check("R5 borrow from divider", 12'h4FF, 1);
  endtask

  task automatic testWrap();
    doReset(); setWord(12'h000);
    strobe(3'd2); check("R6 underflow wraps", 12'hFFF, 1);
    strobe(3'd5); check("R6 overflow wraps", 12'h01F, 0);
  endtask

  task automatic testClamp();
    setWord(12'h9FF); check("R7 divider 9 passes", 12'h9FF, model == 12'h9FF ? modelStable : 0);
    strobe(3'd3); check("R7 divider A clamps", 12'hA00, 1);
    setWord(12'hF10); check("R7 divider F clamps", 12'hF10, modelStable);
    strobe(3'd0); check("R7 subtract recovers", 12'hEF0, 0);
  endtask

  initial begin
    fork
      begin
        testReset(); testSteps(); testIdle(); testCarry(); testWrap(); testClamp();
        doReset(); check("R1 reset after activity", 12'h480, 0);
      end
      begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule